// File: doc/BRIEF.md
# Parallel-Serial FIR Filter

This block is a finite impulse response filter that shares a small set of multipliers across a long list of taps. Each accepted input sample enters a delay line that holds the most recent TAPS samples. The block then computes the filter output over TAPS/LANES consecutive cycles. In every cycle, each of the LANES multiplier lanes picks one delay-line entry through its own multiplexer and reads the matching coefficient from its own small ROM. The LANES products and the running total are added together in one wide adder. When the last group has been added, the full-precision signed result appears on the output with a one-cycle valid pulse.

Each lane ROM holds four coefficient banks, and a 2-bit select picks the bank. The select is captured when a sample is accepted, so the whole computation uses one bank. A control state machine has three states. IDLE waits for a sample. RUN issues one tap group per cycle. FLUSH waits out the two pipeline stages that follow the lane registers. The transitions are:
- IDLE to RUN when an input pulse is accepted.
- RUN to FLUSH after the last group is issued.
- FLUSH to IDLE after two cycles.

The output pulse comes in the same cycle in which the machine returns to IDLE. The result width grows by ceil(log2 TAPS) bits over the product width, which makes 44 bits at the defaults.

Top module: `fir_ps_filter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: Each result equals the sum over i = 0..TAPS-1 of h_b[i]·x[m-i]. Here x[m] is the newest accepted sample, x[m-i] is the sample accepted i acceptances earlier, and b is the captured bank. The sum is computed with no rounding or truncation.
- R3: The coefficient banks, by `sel` value, are: 0 gives h[i] = 1; 1 gives h[i] = i - 128; 2 gives h[i] = ((73·i + 19) mod 4096) - 2048; 3 gives h[i] = -131072.
- R4: `out_valid` is high for exactly one cycle. It is sampled high at the 18th rising edge after the edge that accepted the sample, which is TAPS/LANES + 2 edges.
- R5: An `in_valid` pulse is accepted only when the block is idle. A pulse seen from the accepting edge up to and including the edge that raises `out_valid` is dropped. A dropped pulse does not enter the delay line and produces no result.
- R6: The bank is taken from `sel` at the accepting edge. Later changes to `sel` do not affect that result.
- R7: The result is a 44-bit two's-complement value that holds the extreme sums without overflow. All samples at -131072 in bank 3 give 2^42. All samples at 131071 in bank 3 give -131071·131072·256.
- R8: `out_data` keeps its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of control and output (not the delay line) |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | 18 | Signed input sample |
| sel | input | 2 | Coefficient bank select |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 44 | Signed full-precision result |

## Verification
The delay line is first filled with pseudo-random samples in bank 0. Results in that bank must equal plain sums of the window, which shows that every tap is reached. Random samples in banks 1 and 2 then give weights that differ for every tap, so a wrong lane-to-tap mapping or a wrong bank address changes the result. A run of constant extreme samples in bank 3 tests the full 44-bit growth with both signs. Other pulses test that `sel` is held at capture, that pulses arriving while busy are dropped, and that the timing of the one-cycle strobe is exact.

// File: rtl/fir_ps_pkg.sv
package fir_ps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } fir_state_t;

    localparam int BANK_W = 2;

    // Coefficient of tap idx in bank bk; used as constant ROM content.
    function automatic int coef_value(input logic [BANK_W-1:0] bk, input int idx);
        int v;
        unique case (bk)
            2'd0:    v = 1;
            2'd1:    v = idx - 128;
            2'd2:    v = ((idx * 73 + 19) % 4096) - 2048;
            default: v = -131072;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fir_ps_delay.sv
module fir_ps_delay #(
    parameter int TAPS = 256,
    parameter int DW   = 18
) (
    input  logic                 clk,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [TAPS]
);

    // Sample store without reset: only accepted samples move it.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            taps[0] <= din;
            for (int i = 1; i < TAPS; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/fir_ps_lane.sv
module fir_ps_lane #(
    parameter int LANE   = 0,
    parameter int LANES  = 16,
    parameter int PHASES = 16,
    parameter int DW     = 18,
    parameter int CW     = 18,
    parameter int PW     = 4
) (
    input  logic                    clk,
    input  logic [PW-1:0]           phase,
    input  logic [1:0]              bank,
    input  logic signed [DW-1:0]    taps [PHASES],
    output logic signed [DW+CW-1:0] prod
);
    import fir_ps_pkg::*;

    logic signed [DW-1:0] data_q;
    logic signed [CW-1:0] coef_q;

    // Stage 1: multiplexer pick and ROM read at {bank, phase}.
    // Stage 2: registered product.
    always_ff @(posedge clk) begin
        data_q <= taps[phase];
        coef_q <= CW'(coef_value(bank, int'(phase) * LANES + LANE));
        prod   <= data_q * coef_q;
    end

endmodule

// File: rtl/fir_ps_ctrl.sv
module fir_ps_ctrl #(
    parameter int PHASES = 16,
    parameter int PW     = 4,
    parameter int PIPE   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    sel,
    output logic          accept,
    output logic          busy,
    output logic [PW-1:0] phase,
    output logic [1:0]    bank,
    output logic          issue,
    output logic          issue_first,
    output logic          issue_last
);
    import fir_ps_pkg::*;

    fir_state_t state_q, state_d;
    logic run_last, flush_done;

    assign run_last   = (phase == PW'(PHASES - 1));
    assign flush_done = (phase == PW'(PIPE - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)   state_d = ST_RUN;
            ST_RUN:   if (run_last)   state_d = ST_FLUSH;
            ST_FLUSH: if (flush_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Phase counter and captured bank
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            bank  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    phase <= '0;
                    if (in_valid) bank <= sel;
                end
                ST_RUN:   phase <= run_last ? '0 : phase + 1'b1;
                ST_FLUSH: phase <= flush_done ? '0 : phase + 1'b1;
                default:  phase <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        accept      = 1'b0;
        busy        = 1'b1;
        issue       = 1'b0;
        issue_first = 1'b0;
        issue_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = in_valid;
            end
            ST_RUN: begin
                issue       = 1'b1;
                issue_first = (phase == '0);
                issue_last  = run_last;
            end
            default: ;
        endcase
    end

    // R6: bank frozen for the whole computation
    p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(bank));

    // R4: every computation starts at group 0
    p_run_enter_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_RUN) |-> (phase == '0));

    // R5: a busy machine never takes a sample
    p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q != ST_IDLE) && !accept);

endmodule

// File: rtl/fir_ps_filter.sv
module fir_ps_filter #(
    parameter  int TAPS  = 256,
    parameter  int LANES = 16,
    parameter  int DW    = 18,
    parameter  int CW    = 18,
    localparam int AW    = DW + CW + $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [1:0]           sel,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_data
);
    localparam int PHASES = TAPS / LANES;
    localparam int PW     = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int PRW    = DW + CW;

    logic                  accept, busy, issue, issue_first, issue_last;
    logic [PW-1:0]         phase;
    logic [1:0]            bank;
    logic signed [DW-1:0]  taps  [TAPS];
    logic signed [PRW-1:0] prods [LANES];

    fir_ps_ctrl #(.PHASES(PHASES), .PW(PW), .PIPE(2)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .sel         (sel),
        .accept      (accept),
        .busy        (busy),
        .phase       (phase),
        .bank        (bank),
        .issue       (issue),
        .issue_first (issue_first),
        .issue_last  (issue_last)
    );

    fir_ps_delay #(.TAPS(TAPS), .DW(DW)) u_delay (
        .clk      (clk),
        .shift_en (accept),
        .din      (in_data),
        .taps     (taps)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [DW-1:0] lane_taps [PHASES];
        for (genvar j = 0; j < PHASES; j++) begin : g_pick
            assign lane_taps[j] = taps[j*LANES + k];
        end
        fir_ps_lane #(
            .LANE(k), .LANES(LANES), .PHASES(PHASES),
            .DW(DW), .CW(CW), .PW(PW)
        ) u_lane (
            .clk   (clk),
            .phase (phase),
            .bank  (bank),
            .taps  (lane_taps),
            .prod  (prods[k])
        );
    end

    // Control flags follow the two lane register stages.
    logic s1_v, s1_first, s1_last;
    logic s2_v, s2_first, s2_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            {s1_v, s1_first, s1_last} <= '0;
            {s2_v, s2_first, s2_last} <= '0;
        end else begin
            {s1_v, s1_first, s1_last} <= {issue, issue_first, issue_last};
            {s2_v, s2_first, s2_last} <= {s1_v, s1_first, s1_last};
        end
    end

    // (LANES+1)-input adder: all lane products plus the running total.
    logic signed [AW-1:0] acc_q, acc_base, group_sum;

    always_comb begin
        acc_base  = s2_first ? '0 : acc_q;
        group_sum = acc_base;
        for (int k = 0; k < LANES; k++) begin
            group_sum = group_sum + AW'(prods[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (s2_v) begin
                acc_q <= group_sum;
                if (s2_last) begin
                    out_data  <= group_sum;
                    out_valid <= 1'b1;
                end
            end
        end
    end

    // R4: result strobe lasts one cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: result register moves only with the strobe
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R4: strobe coincides with the return to idle
    p_out_idle_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);

endmodule

// File: tb/fir_ps_filter_test.sv
module fir_ps_filter_test;

    localparam int TAPS = 256;
    localparam int LAT  = 18;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [17:0] in_data = '0;
    logic [1:0]         sel = '0;
    logic               out_valid;
    logic signed [43:0] out_data;

    always #5 clk = ~clk;

    fir_ps_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .sel(sel), .out_valid(out_valid), .out_data(out_data)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit run_cmp = 0;
    string cur_tag = "R2";

    function automatic longint bench_coef(int b, int i);
        case (b)
            0:       return 1;
            1:       return longint'(i - 128);
            2:       return longint'(((i * 73 + 19) % 4096) - 2048);
            default: return -131072;
        endcase
    endfunction

    // Behavioural reference model
    int     hist [TAPS];
    int     nhist = 0;
    int     cnt = 0;
    bit     exp_valid = 0;
    longint exp_data = 0;
    longint pend = 0;
    bit     known = 1;
    bit     pend_known = 0;

    always @(posedge clk) begin
        if (rst) begin
            cnt = 0; exp_valid = 0; exp_data = 0; known = 1;
        end else begin
            exp_valid = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    exp_valid = 1; exp_data = pend; known = pend_known;
                end
            end else if (in_valid) begin
                for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'(in_data);
                nhist++;
                pend = 0;
                for (int i = 0; i < TAPS; i++)
                    pend += bench_coef(int'(sel), i) * longint'(hist[i]);
                pend_known = (nhist >= TAPS);
                cnt = LAT;
            end
        end
    end

    // Comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            compared++;
            if (out_valid !== exp_valid) begin
                mismatched++;
                $display("FAIL R4: out_valid=%0b expected %0b at %0t", out_valid, exp_valid, $time);
            end
            if (known) begin
                compared++;
                if (out_data !== 44'(exp_data)) begin
                    mismatched++;
                    $display("FAIL %s: out_data=%0d expected %0d at %0t",
                             exp_valid ? cur_tag : "R8", out_data, exp_data, $time);
                end
            end
        end
    end

    int unsigned lfsr = 32'h1234_5678;
    function automatic int next_rand();
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        return int'($signed(lfsr[17:0]));
    endfunction

    task automatic pulse(input int val, input int bank);
        @(negedge clk);
        in_data = 18'(val); sel = 2'(bank); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(input int val, input int bank);
        pulse(val, bank);
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || out_data !== 44'd0) begin
            mismatched++;
            $display("FAIL R1: out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
        end
        run_cmp = 1;

        // R2: fill the window in bank 0, then plain window sums
        cur_tag = "R2";
        for (int i = 0; i < TAPS + 20; i++) send(next_rand(), 0);

        // R3: per-tap weights in banks 1 and 2, plus an impulse through bank 1
        cur_tag = "R3";
        for (int i = 0; i < 12; i++) send(next_rand(), 1);
        for (int i = 0; i < 12; i++) send(next_rand(), 2);
        send(1, 1);
        for (int i = 0; i < 6; i++) send(0, 1);

        // R6: select changes while a computation runs
        cur_tag = "R6";
        for (int i = 0; i < 4; i++) begin
            pulse(next_rand(), 2);
            repeat (3) @(negedge clk);
            sel = 2'd1;
            repeat (LAT - 3) @(negedge clk);
        end

        // R5: pulses inside the busy window are dropped
        cur_tag = "R5";
        for (int i = 0; i < 4; i++) begin
            pulse(next_rand(), 2);
            repeat (5) @(negedge clk);
            pulse(77777, 2);
            repeat (LAT - 6) @(negedge clk);
            pulse(-5555, 1);
            repeat (LAT) @(negedge clk);
        end

        // R7: extreme sums of both signs
        cur_tag = "R7";
        for (int i = 0; i < TAPS; i++) send(-131072, 3);
        for (int i = 0; i < TAPS; i++) send(131071, 3);

        cur_tag = "R2";
        for (int i = 0; i < 10; i++) send(next_rand(), 2);
        repeat (LAT + 6) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R4: watchdog expired, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule